// File: doc/BRIEF.md
# Glitch-Free Split Period Register Writer

This block takes a new tone period from a controller and loads it into a sound generator. The generator keeps its 12-bit period in two registers: the low 8 bits at one address and the upper 4 bits at the next address. A naive update writes the two halves in a fixed order. That can leave a short-lived combination in the registers that is far below both the old and the new period. One example is a move from 0x100 to 0x0FF with the upper half written first, which exposes a period of zero. A generator whose phase counter compares against the period resets its phase when that happens, and the result is an audible click.

The writer keeps a record of what each generator register currently holds. It updates the record from its own completed bus writes. For each accepted request it issues one register write at a time, choosing the next write from the difference between the record and the target. In ordered mode, a falling period gets its low byte first and a rising period gets its high byte first. Bytes that already match are not written. In saturating mode, the low byte is first raised to all ones, then the high byte is written, then the final low byte. Each of these writes is skipped when it would not change the register.

A request is a period plus a mode bit. Both are captured when the valid/ready handshake completes. The request port stays not-ready until the sequence has finished.

Top module: `spw_writer`

## Requirements
- R1: After reset, `req_ready` is 1, `wr_strobe` is 0, and the recorded generator period is 0, so a first request for period 0 issues no write.
- R2: A write to address 0 carries the period's low 8 bits. A write to address 1 carries the upper 4 bits zero-extended to the 8-bit data bus. No other address is ever used.
- R3: A request is accepted in a cycle with `req_valid` and `req_ready` both high. `req_ready` is 0 from the following cycle until the sequence ends, and then returns to 1.
- R4: A request equal to the recorded period issues no write.
- R5: When exactly one half differs, only that half is written: in ordered mode always, and in saturating mode when the high half is unchanged.
- R6: In ordered mode, when both halves differ and the target is smaller than the recorded period, address 0 is written before address 1.
- R7: In ordered mode, when both halves differ and the target is larger, address 1 is written before address 0.
- R8: In saturating mode, a high-half change produces up to three writes, in this order: 0xFF to address 0 (omitted when the low register already holds 0xFF), the new high half, and the new low byte (omitted when it is 0xFF).
- R9: A write completes in each cycle where `wr_strobe` and `wr_ready` are both high. While `wr_strobe` is high and `wr_ready` is low, the strobe, address and data hold their values.
- R10: During a sequence, the period formed by the two generator registers never drops below the smaller of the starting and target periods. For example, 0x100 to 0x0FF never shows 0.
- R11: The mode bit is sampled at acceptance. Changing `req_saturate` while a sequence runs does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | New period offered |
| req_ready | output | 1 | Writer idle and able to accept |
| req_period | input | 12 | Target tone period |
| req_saturate | input | 1 | 1 selects the saturating sequence, 0 the ordered sequence |
| wr_strobe | output | 1 | Register write pending |
| wr_addr | output | 4 | Generator register address (0 low, 1 high) |
| wr_data | output | 8 | Register write data |
| wr_ready | input | 1 | Generator accepts the pending write this cycle |

## Verification
Two functions can land in the same cycle. One is the completion of a bus write, which changes the recorded registers. The other is the choice of the next write, which reads those same registers. When `wr_ready` is high on consecutive cycles, the writer must use the just-updated record for the following write. The bench provokes this with a pseudo-random `wr_ready` pattern that often stays high several cycles in a row and sometimes stalls mid-sequence. It runs a long series of period walks that cross byte boundaries in both directions, in both modes. Each observed write sequence is judged against an order computed from the requirements. A model of the generator registers, built from the bus, checks the floor of R10 after every completed write.

// File: rtl/spw_pkg.sv
package spw_pkg;
    typedef enum logic {
        MODE_ORDERED  = 1'b0,
        MODE_SATURATE = 1'b1
    } spw_mode_e;

    localparam int REG_LO_IDX = 0;
    localparam int REG_HI_IDX = 1;
endpackage

// File: rtl/spw_shadow.sv
// Record of the two generator period registers, updated only by completed writes.
module spw_shadow #(
    parameter int LO_W   = 8,
    parameter int HI_W   = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LO_W-1:0]   cur_lo,
    output logic [HI_W-1:0]   cur_hi
);
    import spw_pkg::*;

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_fire) begin
            if (wr_addr == ADDR_W'(REG_LO_IDX)) begin
                regs_d.lo = wr_data[LO_W-1:0];
            end else if (wr_addr == ADDR_W'(REG_HI_IDX)) begin
                regs_d.hi = wr_data[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cur_lo = regs_q.lo;
    assign cur_hi = regs_q.hi;
endmodule

// File: rtl/spw_planner.sv
// Picks the single next register write from the recorded and target halves.
module spw_planner #(
    parameter int LO_W   = 8,
    parameter int HI_W   = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic [LO_W-1:0]   cur_lo,
    input  logic [HI_W-1:0]   cur_hi,
    input  logic [LO_W-1:0]   tgt_lo,
    input  logic [HI_W-1:0]   tgt_hi,
    input  spw_pkg::spw_mode_e mode,
    output logic              need_write,
    output logic [ADDR_W-1:0] next_addr,
    output logic [DATA_W-1:0] next_data
);
    import spw_pkg::*;

    localparam logic [LO_W-1:0] LO_SAT = {LO_W{1'b1}};

    logic lo_diff, hi_diff, falling;

    always_comb begin
        lo_diff    = (cur_lo != tgt_lo);
        hi_diff    = (cur_hi != tgt_hi);
        falling    = ({tgt_hi, tgt_lo} < {cur_hi, cur_lo});
        need_write = 1'b0;
        next_addr  = ADDR_W'(REG_LO_IDX);
        next_data  = DATA_W'(tgt_lo);
        if (mode == MODE_SATURATE) begin
            if (hi_diff) begin
                need_write = 1'b1;
                if (cur_lo != LO_SAT) begin
                    next_addr = ADDR_W'(REG_LO_IDX);
                    next_data = DATA_W'(LO_SAT);
                end else begin
                    next_addr = ADDR_W'(REG_HI_IDX);
                    next_data = DATA_W'(tgt_hi);
                end
            end else if (lo_diff) begin
                need_write = 1'b1;
            end
        end else begin
            if (hi_diff && lo_diff) begin
                need_write = 1'b1;
                if (!falling) begin
                    next_addr = ADDR_W'(REG_HI_IDX);
                    next_data = DATA_W'(tgt_hi);
                end
            end else if (hi_diff) begin
                need_write = 1'b1;
                next_addr  = ADDR_W'(REG_HI_IDX);
                next_data  = DATA_W'(tgt_hi);
            end else if (lo_diff) begin
                need_write = 1'b1;
            end
        end
    end
endmodule

// File: rtl/spw_writer.sv
module spw_writer #(
    parameter int PERIOD_W = 12,
    parameter int LO_W     = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [PERIOD_W-1:0] req_period,
    input  logic                req_saturate,
    output logic                wr_strobe,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    input  logic                wr_ready
);
    import spw_pkg::*;

    localparam int HI_W = PERIOD_W - LO_W;

    typedef struct packed {
        logic                busy;
        spw_mode_e           mode;
        logic [PERIOD_W-1:0] target;
        logic [PERIOD_W-1:0] start;
    } state_t;

    state_t state_d, state_q;

    logic [LO_W-1:0]     cur_lo;
    logic [HI_W-1:0]     cur_hi;
    logic [PERIOD_W-1:0] cur_period;
    logic                plan_need;
    logic [ADDR_W-1:0]   plan_addr;
    logic [DATA_W-1:0]   plan_data;
    logic                wr_fire;

    assign cur_period = {cur_hi, cur_lo};
    assign wr_fire    = wr_strobe && wr_ready;

    spw_shadow #(
        .LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_shadow (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .cur_lo(cur_lo), .cur_hi(cur_hi)
    );

    spw_planner #(
        .LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_planner (
        .cur_lo(cur_lo), .cur_hi(cur_hi),
        .tgt_lo(state_q.target[LO_W-1:0]),
        .tgt_hi(state_q.target[PERIOD_W-1:LO_W]),
        .mode(state_q.mode),
        .need_write(plan_need), .next_addr(plan_addr), .next_data(plan_data)
    );

    always_comb begin
        state_d   = state_q;
        req_ready = !state_q.busy;
        wr_strobe = state_q.busy && plan_need;
        wr_addr   = plan_addr;
        wr_data   = plan_data;
        if (!state_q.busy) begin
            if (req_valid) begin
                state_d.busy   = 1'b1;
                state_d.mode   = spw_mode_e'(req_saturate);
                state_d.target = req_period;
                state_d.start  = cur_period;
            end
        end else if (!plan_need) begin
            state_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{busy: 1'b0, mode: MODE_ORDERED, target: '0, start: '0};
        end else begin
            state_q <= state_d;
        end
    end

    // Lowest period the registers may show while a sequence runs.
    logic [PERIOD_W-1:0] floor_period;
    assign floor_period = (state_q.start < state_q.target) ? state_q.start : state_q.target;

    p_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.busy |-> cur_period >= floor_period);

    p_accept_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !wr_ready) |=> (wr_strobe && $stable(wr_addr) && $stable(wr_data)));

    p_addr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (wr_addr == ADDR_W'(REG_LO_IDX) || wr_addr == ADDR_W'(REG_HI_IDX)));

    p_done_at_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> cur_period == state_q.target);

    p_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && !req_ready && $past(state_q.busy)) |-> $stable(state_q.mode));
endmodule

// File: tb/test_spw_writer.sv
`timescale 1ns/1ps
module test_spw_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_period = '0;
    logic        req_saturate = 1'b0;
    logic        wr_strobe;
    logic [3:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        wr_ready = 1'b0;

    int vectors = 0;
    int fails = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [11:0] model_cur = '0;
    logic [11:0] vis = '0;

    always #4 clk = ~clk;

    spw_writer i_spw_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_period(req_period), .req_saturate(req_saturate),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [11:0] tgt, input logic sat);
        int          exp_n = 0;
        int          got_n = 0;
        logic [3:0]  exp_a [3];
        logic [7:0]  exp_d [3];
        logic [3:0]  got_a [3];
        logic [7:0]  got_d [3];
        logic [7:0]  lo_c = model_cur[7:0];
        logic [3:0]  hi_c = model_cur[11:8];
        logic [11:0] flo = (model_cur < tgt) ? model_cur : tgt;
        string       tag;
        bit          first = 1'b1;
        bit          p_hold = 1'b0;
        logic [3:0]  p_a = '0;
        logic [7:0]  p_d = '0;
        bit          done = 1'b0;
        if (sat && hi_c != tgt[11:8]) begin
            if (lo_c != 8'hFF) begin exp_a[exp_n] = 4'd0; exp_d[exp_n] = 8'hFF; exp_n++; end
            exp_a[exp_n] = 4'd1; exp_d[exp_n] = {4'h0, tgt[11:8]}; exp_n++;
            if (tgt[7:0] != 8'hFF) begin exp_a[exp_n] = 4'd0; exp_d[exp_n] = tgt[7:0]; exp_n++; end
            tag = "R8";
        end else if (hi_c != tgt[11:8] && lo_c != tgt[7:0]) begin
            if (tgt < model_cur) begin
                exp_a[0] = 4'd0; exp_d[0] = tgt[7:0];
                exp_a[1] = 4'd1; exp_d[1] = {4'h0, tgt[11:8]};
                tag = "R6";
            end else begin
                exp_a[0] = 4'd1; exp_d[0] = {4'h0, tgt[11:8]};
                exp_a[1] = 4'd0; exp_d[1] = tgt[7:0];
                tag = "R7";
            end
            exp_n = 2;
        end else if (hi_c != tgt[11:8]) begin
            exp_a[0] = 4'd1; exp_d[0] = {4'h0, tgt[11:8]}; exp_n = 1; tag = "R5";
        end else if (lo_c != tgt[7:0]) begin
            exp_a[0] = 4'd0; exp_d[0] = tgt[7:0]; exp_n = 1; tag = "R5";
        end else begin
            tag = "R4";
        end

        @(negedge clk);
        req_valid = 1'b1; req_period = tgt; req_saturate = sat;
        #1;
        chk(req_ready == 1'b1, "R3 idle ready", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0; req_saturate = ~sat; // R11: changed after acceptance
        for (int cyc = 0; cyc < 64 && !done; cyc++) begin
            wr_ready = lfsr[0] | lfsr[1];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (first) begin
                chk(req_ready == 1'b0, "R3 busy after accept", int'(req_ready), 0);
                first = 1'b0;
            end
            if (req_ready && cyc > 0) begin
                done = 1'b1;
            end else begin
                if (p_hold) begin
                    chk(wr_strobe && wr_addr == p_a && wr_data == p_d, "R9 hold",
                        {wr_strobe, wr_addr, wr_data}, {1'b1, p_a, p_d});
                end
                if (wr_strobe && wr_ready) begin
                    if (got_n < 3) begin got_a[got_n] = wr_addr; got_d[got_n] = wr_data; end
                    got_n++;
                    chk(wr_addr <= 4'd1 && (wr_addr != 4'd1 || wr_data[7:4] == 4'h0),
                        "R2 address/data form", {wr_addr, wr_data}, 0);
                    if (wr_addr == 4'd0) vis[7:0] = wr_data;
                    else if (wr_addr == 4'd1) vis[11:8] = wr_data[3:0];
                    chk(vis >= flo, "R10 floor", vis, flo);
                end
                p_hold = wr_strobe && !wr_ready;
                p_a = wr_addr; p_d = wr_data;
                @(negedge clk);
            end
        end
        chk(done, "R3 sequence ended", int'(done), 1);
        chk(got_n == exp_n, {tag, " write count"}, got_n, exp_n);
        for (int i = 0; i < 3; i++) begin
            if (i < exp_n && i < got_n) begin
                chk(got_a[i] == exp_a[i] && got_d[i] == exp_d[i], {tag, " write order R11"},
                    {got_a[i], got_d[i]}, {exp_a[i], exp_d[i]});
            end
        end
        chk(vis == tgt, {tag, " final period"}, vis, tgt);
        model_cur = tgt;
        wr_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [11:0] t;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && wr_strobe == 1'b0, "R1 reset outputs", {req_ready, wr_strobe}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && wr_strobe == 1'b0, "R1 after release", {req_ready, wr_strobe}, 2'b10);
        run_xfer(12'h000, 1'b0); // R1: recorded period is 0
        run_xfer(12'h100, 1'b0);
        run_xfer(12'h0FF, 1'b0); // R10: no zero on the way down
        run_xfer(12'h100, 1'b1); // R8: FF write skipped
        run_xfer(12'h0FF, 1'b1); // R8: final low write skipped
        run_xfer(12'h0FF, 1'b1); // R4
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 1500; k++) begin
                case (k % 4)
                    0: t = 12'(k * 2749 + 251 * (k >> 3));
                    1: t = {model_cur[11:8], 8'h00} - 12'd1;
                    2: t = model_cur + 12'd1;
                    default: t = model_cur;
                endcase
                run_xfer(t, m[0]);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule